// File: doc/BRIEF.md
# Pulse Speed Capture Unit

This block measures the rate of an incoming pulse train and keeps a running signed total of the pulses it has seen. It has two input modes. In single-phase mode, one input carries the pulses. In two-phase mode, two inputs carry quadrature signals A and B. The phase order of A and B gives the direction, so both the total and the speed carry a sign.

Speed is not measured over a fixed time gate. The block instead counts cycles of the reference clock that span a programmable number N of pulse intervals. It then divides N times the reference frequency by that cycle count in a sequential divider. N and the mode are taken only at a load strobe, and N is clamped to a legal range for the mode. If the input stays quiet for a timeout window, the speed drops to zero.

The block only runs once it is enabled. If another function already owns the counting resource when enable is raised, the block refuses to run and raises a busy flag instead.

Top module: `pulse_speed_capture`

## Requirements
- R1: After reset the total is 0, the speed is 0, valid is 0 and busy is 0. In single-phase mode (mode code 0), each rising edge on `pulse_a` while running adds exactly 1 to the total.
- R2: In two-phase mode (mode code 1), the signals are taken as the pair {A,B}. The change 00→10 (A rises while B is low) adds 1. The change 10→00 (A falls while B is low) subtracts 1. This gives one count per full quadrature cycle. A change in which A and B flip in the same sampled cycle is never counted.
- R3: The first counted pulse after arming only starts a window. Each later group of N pulses closes a window. The speed is then floor(N·F_REF_HZ / C), where C is the number of reference cycles the window spanned. A window that closes while the divider is still working is dropped.
- R4: The mode and N are latched only at a cycle with `cfg_load` high. The load also restarts the current window. Changing `cfg_n` without a load has no effect. After reset, N is 1 and the mode is single-phase.
- R5: A loaded N is clamped, not rejected. The range is 1..100 in single-phase mode and 2..100 in two-phase mode.
- R6: The speed is a signed 16-bit value in Hz and saturates at +10000 and -10000. It is negative when the pulse that closed the window was a reverse step.
- R7: If no counted pulse arrives for TIMEOUT_CYC reference cycles while armed, the speed becomes 0, valid drops to 0 and the window is disarmed.
- R8: If `res_claimed` is high when `en` is raised, the block does not run and raises `busy`. While it is not running the total does not change. Dropping `en` clears `busy`.
- R9: `speed_valid` rises with every speed update from the divider and stays high until reset or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, F_REF_HZ |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request |
| res_claimed | input | 1 | Counting resource already owned elsewhere |
| cfg_mode | input | 1 | 0 single-phase, 1 two-phase |
| cfg_n | input | 8 | Requested pulses per speed window |
| cfg_load | input | 1 | Latch mode and N, restart window |
| pulse_a | input | 1 | Pulse input / phase A (asynchronous) |
| pulse_b | input | 1 | Phase B (asynchronous) |
| speed_hz | output | 16 | Signed speed in Hz |
| pulse_count | output | 32 | Signed accumulated pulse total |
| speed_valid | output | 1 | Speed holds a computed value |
| busy | output | 1 | Enable refused because of a resource conflict |

## Verification
Two events can land in the same cycle: a pulse that closes a window, and the divider still working on the previous window. Only one of them can be served. With N at 1, the saturation test spaces pulses 8 cycles apart, which is far shorter than the divider latency, so most closing pulses arrive while the divider is busy. Those windows must be dropped cleanly, so the speed settles at the +10000 limit while the total still counts every pulse. The 1x counting mode also sees a similar clash: when A and B flip in the same sampled cycle, the step is judged uncounted by reading the total back.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int SPEED_LIM = 10000;
    localparam int N_MAX     = 100;

    typedef enum logic {
        PSC_SINGLE = 1'b0,
        PSC_QUAD   = 1'b1
    } psc_mode_e;

    typedef struct packed {
        logic hit;
        logic rev;
    } psc_step_t;

    function automatic logic [6:0] clamp_n(psc_mode_e m, logic [7:0] raw);
        logic [7:0] lo;
        lo = (m == PSC_QUAD) ? 8'd2 : 8'd1;
        if (raw < lo)
            return lo[6:0];
        else if (raw > 8'(N_MAX))
            return 7'(N_MAX);
        else
            return raw[6:0];
    endfunction

endpackage

// File: rtl/psc_edge_front.sv
module psc_edge_front
    import psc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  psc_mode_e  mode,
    input  logic       pa,
    input  logic       pb,
    output psc_step_t  step
);
    logic [1:0] sync_a, sync_b;
    logic [1:0] cur, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= '0;
            sync_b <= '0;
            prev   <= '0;
        end else begin
            sync_a <= {sync_a[0], pa};
            sync_b <= {sync_b[0], pb};
            prev   <= cur;
        end
    end

    assign cur = {sync_a[1], sync_b[1]};

    always_comb begin
        step = '0;
        if (mode == PSC_SINGLE) begin
            step.hit = cur[1] & ~prev[1];
        end else begin
            // only the two single-bit changes next to state 00 count
            if (prev == 2'b00 && cur == 2'b10) begin
                step.hit = 1'b1;
            end else if (prev == 2'b10 && cur == 2'b00) begin
                step.hit = 1'b1;
                step.rev = 1'b1;
            end
        end
    end
endmodule

// File: rtl/psc_divider.sv
module psc_divider #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem;
    logic [W-1:0]  den_q;
    logic [CW-1:0] left;
    logic [W:0]    trial;
    logic          fits;

    assign trial = {rem, quo[W-1]};
    assign fits  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            quo   <= '0;
            den_q <= '0;
            left  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem   <= '0;
                quo   <= num;
                den_q <= den;
                left  <= CW'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (fits) begin
                    rem <= W'(trial - {1'b0, den_q});
                end else begin
                    rem <= trial[W-1:0];
                end
                quo  <= {quo[W-2:0], fits};
                left <= left - 1'b1;
                if (left == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pulse_speed_capture.sv
module pulse_speed_capture
    import psc_pkg::*;
#(
    parameter int F_REF_HZ    = 1_000_000,
    parameter int TIMEOUT_CYC = 1_000_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               res_claimed,
    input  logic               cfg_mode,
    input  logic [7:0]         cfg_n,
    input  logic               cfg_load,
    input  logic               pulse_a,
    input  logic               pulse_b,
    output logic signed [15:0] speed_hz,
    output logic signed [31:0] pulse_count,
    output logic               speed_valid,
    output logic               busy
);
    localparam int NUM_W = $clog2(N_MAX * F_REF_HZ + 1);
    localparam int EL_W  = $clog2(N_MAX * TIMEOUT_CYC + 1);
    localparam int W     = (NUM_W > EL_W) ? NUM_W : EL_W;
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);

    psc_mode_e   mode_act;
    logic [6:0]  n_act;
    logic        running;
    logic        armed;
    logic [6:0]  win_pulses;
    logic [EL_W-1:0] elapsed;
    logic [TO_W-1:0] idle;
    logic        dir_cap;
    psc_step_t   step;

    logic         div_start, div_busy, div_done;
    logic [W-1:0] div_num, div_den, div_quo;
    logic         win_close;
    logic [15:0]  sat_mag;

    psc_edge_front u_front (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_act),
        .pa   (pulse_a),
        .pb   (pulse_b),
        .step (step)
    );

    psc_divider #(.W(W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo)
    );

    assign win_close = running && !cfg_load && step.hit && armed
                       && (win_pulses + 7'd1 == n_act);
    assign div_start = win_close && !div_busy;
    assign div_num   = W'(n_act) * W'(F_REF_HZ);
    assign div_den   = W'(elapsed) + W'(1);
    assign sat_mag   = (div_quo > W'(SPEED_LIM)) ? 16'(SPEED_LIM) : div_quo[15:0];

    // run / conflict control
    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            busy    <= 1'b0;
        end else if (!en) begin
            running <= 1'b0;
            busy    <= 1'b0;
        end else if (!running && !busy) begin
            if (res_claimed) busy    <= 1'b1;
            else             running <= 1'b1;
        end
    end

    // accumulated total
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_count <= '0;
        end else if (running && step.hit) begin
            pulse_count <= step.rev ? pulse_count - 32'sd1 : pulse_count + 32'sd1;
        end
    end

    // configuration and window tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_act   <= PSC_SINGLE;
            n_act      <= 7'd1;
            armed      <= 1'b0;
            win_pulses <= '0;
            elapsed    <= '0;
            idle       <= '0;
            dir_cap    <= 1'b0;
        end else if (cfg_load) begin
            mode_act   <= psc_mode_e'(cfg_mode);
            n_act      <= clamp_n(psc_mode_e'(cfg_mode), cfg_n);
            armed      <= 1'b0;
            win_pulses <= '0;
            elapsed    <= '0;
            idle       <= '0;
        end else if (running) begin
            if (step.hit) begin
                idle <= '0;
                if (!armed) begin
                    armed      <= 1'b1;
                    win_pulses <= '0;
                    elapsed    <= '0;
                end else if (win_close) begin
                    win_pulses <= '0;
                    elapsed    <= '0;
                    if (div_start) dir_cap <= step.rev;
                end else begin
                    win_pulses <= win_pulses + 7'd1;
                    if (elapsed != '1) elapsed <= elapsed + 1'b1;
                end
            end else if (armed) begin
                if (elapsed != '1) elapsed <= elapsed + 1'b1;
                if (idle == TO_W'(TIMEOUT_CYC - 1)) begin
                    armed      <= 1'b0;
                    win_pulses <= '0;
                    idle       <= '0;
                end else begin
                    idle <= idle + 1'b1;
                end
            end
        end
    end

    // speed result; timeout wins over a completing division
    always_ff @(posedge clk) begin
        if (rst) begin
            speed_hz    <= '0;
            speed_valid <= 1'b0;
        end else if (running && !cfg_load && !step.hit && armed
                     && idle == TO_W'(TIMEOUT_CYC - 1)) begin
            speed_hz    <= '0;
            speed_valid <= 1'b0;
        end else if (div_done) begin
            speed_hz    <= dir_cap ? -$signed(sat_mag) : $signed(sat_mag);
            speed_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/psc_checker.sv
module psc_checker
    import psc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic signed [15:0] speed_hz,
    input logic signed [31:0] pulse_count,
    input logic               speed_valid,
    input logic               busy,
    input logic               running,
    input psc_mode_e          mode_act,
    input logic [6:0]         n_act
);
    p_speed_limit_r6: assert property (@(posedge clk) disable iff (rst)
        (speed_hz <= 16'sd10000) && (speed_hz >= -16'sd10000));

    p_n_bounds_r5: assert property (@(posedge clk) disable iff (rst)
        (n_act >= 7'd1) && (n_act <= 7'd100)
        && !(mode_act == PSC_QUAD && n_act < 7'd2));

    p_busy_stopped_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !running);

    p_hold_total_r8: assert property (@(posedge clk) disable iff (rst)
        !running |=> $stable(pulse_count));

    p_unit_step_r1: assert property (@(posedge clk) disable iff (rst)
        running |=> (pulse_count == $past(pulse_count))
                 || (pulse_count == $past(pulse_count) + 32'sd1)
                 || (pulse_count == $past(pulse_count) - 32'sd1));

    p_invalid_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !speed_valid |-> (speed_hz == 16'sd0));
endmodule

bind pulse_speed_capture psc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .speed_hz    (speed_hz),
    .pulse_count (pulse_count),
    .speed_valid (speed_valid),
    .busy        (busy),
    .running     (running),
    .mode_act    (mode_act),
    .n_act       (n_act)
);

// File: tb/pulse_speed_capture_tb.sv
module pulse_speed_capture_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en = 1'b0;
    logic               res_claimed = 1'b0;
    logic               cfg_mode = 1'b0;
    logic [7:0]         cfg_n = 8'd1;
    logic               cfg_load = 1'b0;
    logic               pulse_a = 1'b0;
    logic               pulse_b = 1'b0;
    logic signed [15:0] speed_hz;
    logic signed [31:0] pulse_count;
    logic               speed_valid;
    logic               busy;

    always #2 clk = ~clk;

    pulse_speed_capture #(.F_REF_HZ(100000), .TIMEOUT_CYC(3000)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .res_claimed (res_claimed),
        .cfg_mode    (cfg_mode),
        .cfg_n       (cfg_n),
        .cfg_load    (cfg_load),
        .pulse_a     (pulse_a),
        .pulse_b     (pulse_b),
        .speed_hz    (speed_hz),
        .pulse_count (pulse_count),
        .speed_valid (speed_valid),
        .busy        (busy)
    );

    typedef struct {
        string              tag;
        logic signed [15:0] spd;
        logic signed [31:0] cnt;
        logic               vld;
        logic               bsy;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    logic signed [31:0] exp_cnt = 0;
    logic               counting = 1'b0;
    bit                 finished = 1'b0;

    task automatic report_done();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: pops expectations and compares against outputs
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (speed_hz !== e.spd) begin
                n_bad++;
                $display("FAIL %s speed actual=%0d expected=%0d", e.tag, speed_hz, e.spd);
            end
            n_cmp++;
            if (pulse_count !== e.cnt) begin
                n_bad++;
                $display("FAIL %s count actual=%0d expected=%0d", e.tag, pulse_count, e.cnt);
            end
            n_cmp++;
            if (speed_valid !== e.vld) begin
                n_bad++;
                $display("FAIL %s valid actual=%0b expected=%0b", e.tag, speed_valid, e.vld);
            end
            n_cmp++;
            if (busy !== e.bsy) begin
                n_bad++;
                $display("FAIL %s busy actual=%0b expected=%0b", e.tag, busy, e.bsy);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(string tag, int spd, int cnt, bit vld, bit bsy);
        exp_t e;
        e.tag = tag;
        e.spd = 16'(spd);
        e.cnt = 32'(cnt);
        e.vld = vld;
        e.bsy = bsy;
        exp_q.push_back(e);
        tick(1);
    endtask

    task automatic load_cfg(bit m, int n);
        cfg_mode = m;
        cfg_n    = 8'(n);
        cfg_load = 1'b1;
        tick(1);
        cfg_load = 1'b0;
        tick(2);
    endtask

    task automatic pulse_single(int gap);
        pulse_a = 1'b1;
        tick(gap / 2);
        pulse_a = 1'b0;
        tick(gap - gap / 2);
        if (counting) exp_cnt = exp_cnt + 1;
    endtask

    task automatic quad_fwd(int q);
        pulse_a = 1'b1; tick(q);
        pulse_b = 1'b1; tick(q);
        pulse_a = 1'b0; tick(q);
        pulse_b = 1'b0; tick(q);
        exp_cnt = exp_cnt + 1;
    endtask

    task automatic quad_rev(int q);
        pulse_b = 1'b1; tick(q);
        pulse_a = 1'b1; tick(q);
        pulse_b = 1'b0; tick(q);
        pulse_a = 1'b0; tick(q);
        exp_cnt = exp_cnt - 1;
    endtask

    // five pulses: arming pulse, then gaps 60,120,60,120
    task automatic alt_train();
        pulse_single(60);
        pulse_single(120);
        pulse_single(60);
        pulse_single(120);
        pulse_single(30);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        report_done();
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        expect_now("R1 reset state", 0, 0, 0, 0);

        // R8: conflict on enable
        res_claimed = 1'b1;
        en = 1'b1;
        tick(3);
        for (int i = 0; i < 3; i++) pulse_single(20);
        tick(10);
        expect_now("R8 conflict refuses start", 0, 0, 0, 1);

        en = 1'b0;
        res_claimed = 1'b0;
        tick(2);
        en = 1'b1;
        tick(2);
        counting = 1'b1;
        expect_now("R8 clean enable clears busy", 0, 0, 0, 0);

        // R1 R3 R9: uniform single-phase train
        load_cfg(1'b0, 1);
        for (int i = 0; i < 5; i++) pulse_single(60);
        tick(100);
        expect_now("R3 R9 uniform gap 60", 1666, exp_cnt, 1, 0);

        // R3: N=1 follows the last interval
        load_cfg(1'b0, 1);
        alt_train();
        tick(100);
        expect_now("R3 N=1 last interval", 833, exp_cnt, 1, 0);

        // R4: N=2 averages two intervals
        load_cfg(1'b0, 2);
        alt_train();
        tick(100);
        expect_now("R4 N=2 window", 1111, exp_cnt, 1, 0);

        // R5: N=0 clamps to 1 in single-phase mode
        load_cfg(1'b0, 0);
        alt_train();
        tick(100);
        expect_now("R5 clamp low single", 833, exp_cnt, 1, 0);

        // R4: new N without a load has no effect
        cfg_n = 8'd2;
        tick(2);
        alt_train();
        tick(100);
        expect_now("R4 no load keeps N", 833, exp_cnt, 1, 0);

        // R7: timeout
        tick(3100);
        expect_now("R7 timeout zeroes speed", 0, exp_cnt, 0, 0);

        // R6: saturation, with most windows closing into a busy divider
        load_cfg(1'b0, 1);
        for (int i = 0; i < 12; i++) pulse_single(8);
        tick(100);
        expect_now("R6 saturate positive", 10000, exp_cnt, 1, 0);

        // R2 R5: two-phase forward, N=1 clamps to 2
        load_cfg(1'b1, 1);
        quad_fwd(25);
        quad_fwd(50);
        quad_fwd(25);
        quad_fwd(50);
        quad_fwd(25);
        tick(100);
        expect_now("R2 R5 quad forward clamp", 666, exp_cnt, 1, 0);

        // R2 R6: reverse gives negative speed and count-down
        load_cfg(1'b1, 2);
        for (int i = 0; i < 5; i++) quad_rev(25);
        tick(100);
        expect_now("R2 R6 quad reverse", -1000, exp_cnt, 1, 0);

        // R2: simultaneous A/B flips ignored
        for (int i = 0; i < 3; i++) begin
            pulse_a = 1'b1; pulse_b = 1'b1; tick(20);
            pulse_a = 1'b0; pulse_b = 1'b0; tick(20);
        end
        tick(10);
        expect_now("R2 double flip ignored", -1000, exp_cnt, 1, 0);

        tick(5);
        report_done();
    end
endmodule